// File: doc/BRIEF.md
# Set/Clear GPIO Controller

A small register-mapped controller for general-purpose pins, meant as glue logic on a chip's internal bus. One bus word spans every line. Bit n of every register belongs to line n. Software reads pin levels through a data register. It drives lines through set and clear registers, or through the data register itself when those are not built in. A direction register picks, line by line, whether the output driver is enabled.

Build-time parameters set the line count, which optional registers are present, and the sense of the direction bits. Other parameters give a read-only build that can never drive its pins, and a big-endian build that reverses the byte lanes of every bus word. Inputs pass through a two-flop synchronizer. Reads return the result one cycle after the read strobe.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: WIDTH lines (a multiple of 8). Bit n of every register maps to line n. Word addresses are: 0 data, 1 set, 2 clear, 3 direction.
- R2: Each line's input goes through two flops. A read of address 0 presents, on bus_rdata in the next cycle, the synchronized pin levels (1 = high), never the output latch.
- R3: With both set and clear registers built in, writing address 1 raises the latch bits that are 1 in the word. The 0 bits keep their value.
- R4: With the clear register built in, writing address 2 lowers the latch bits that are 1 in the word. The 0 bits keep their value.
- R5: With a set register and no clear register, writing address 1 loads the word into the latch, so 0 bits drive lines low.
- R6: With no set register, writing address 0 loads the latch. When a set register exists, data writes leave the latch alone.
- R7: With DIR_IN_POL=0, a direction bit of 1 enables that line's output and 0 makes it an input.
- R8: With DIR_IN_POL=1, a direction bit of 1 makes the line an input and 0 enables its output.
- R9: With READ_ONLY=1, gpio_oe stays 0 and writes to addresses 0, 1 and 2 never change gpio_out.
- R10: With BIG_ENDIAN=1, byte k of a bus word corresponds to register byte WIDTH/8-1-k, for both writes and reads. With BIG_ENDIAN=0, the bytes map straight across.
- R11: After reset the latch is 0 and every line is an input. The direction register reads all ones in input-polarity builds and all zeros otherwise.
- R12: Reads of addresses 1 and 2 return the latch when that register exists, and return 0 otherwise. Writes to an absent register are ignored. Address 3 reads back the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write word |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Read word, valid the cycle after bus_re |
| gpio_out | output | WIDTH | Output latch, per line |
| gpio_oe | output | WIDTH | Output enable, per line |
| gpio_in | input | WIDTH | Pin levels, asynchronous |

## Verification
The assertions assume that write and read strobes are never asserted together in the same cycle. They also assume that bus_addr is stable while a strobe is high. The bench drives one strobe per transaction at the falling edge and drops it at the next one, so it stays inside those assumptions. Pin inputs are treated as asynchronous. The bench changes them only at falling edges and counts the two synchronizer stages before each read, including one read made too early on purpose to observe the old level.

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl #(
  parameter int WIDTH      = 8,
  parameter int HAS_SET    = 1,
  parameter int HAS_CLR    = 1,
  parameter int DIR_IN_POL = 0,
  parameter int READ_ONLY  = 0,
  parameter int BIG_ENDIAN = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic             bus_re,
  output logic [WIDTH-1:0] bus_rdata,
  output logic [WIDTH-1:0] gpio_out,
  output logic [WIDTH-1:0] gpio_oe,
  input  logic [WIDTH-1:0] gpio_in
);
  localparam int NBYTES = WIDTH / 8;
  localparam logic [1:0] A_DAT = 2'd0, A_SET = 2'd1, A_CLR = 2'd2, A_DIR = 2'd3;
  localparam logic [WIDTH-1:0] DIR_RST = (DIR_IN_POL != 0) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
  localparam bit SET_ON = (HAS_SET != 0) && (READ_ONLY == 0);
  localparam bit CLR_ON = (HAS_CLR != 0) && (READ_ONLY == 0);
  localparam bit DAT_ON = (HAS_SET == 0) && (READ_ONLY == 0);

  function automatic logic [WIDTH-1:0] lanes(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (BIG_ENDIAN != 0)
      for (int b = 0; b < NBYTES; b++) r[8*b +: 8] = v[8*(NBYTES-1-b) +: 8];
    return r;
  endfunction

  logic [WIDTH-1:0] latch_q, latch_d, dir_q, sync1_q, sync2_q, rd_mux, wdat;
  logic wr_dat, wr_set, wr_clr;

  assign wdat   = lanes(bus_wdata);
  assign wr_dat = bus_we && (bus_addr == A_DAT) && DAT_ON;
  assign wr_set = bus_we && (bus_addr == A_SET) && SET_ON;
  assign wr_clr = bus_we && (bus_addr == A_CLR) && CLR_ON;

  always_comb begin
    latch_d = latch_q;
    if (wr_dat) latch_d = wdat;
    if (wr_set) latch_d = (HAS_CLR != 0) ? (latch_q | wdat) : wdat;
    if (wr_clr) latch_d = latch_d & ~wdat;
  end

  always_comb begin
    case (bus_addr)
      A_DAT:   rd_mux = sync2_q;
      A_SET:   rd_mux = (HAS_SET != 0) ? latch_q : '0;
      A_CLR:   rd_mux = (HAS_CLR != 0) ? latch_q : '0;
      default: rd_mux = dir_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '0;
      dir_q     <= DIR_RST;
      sync1_q   <= '0;
      sync2_q   <= '0;
      bus_rdata <= '0;
    end else begin
      latch_q <= latch_d;
      sync1_q <= gpio_in;
      sync2_q <= sync1_q;
      if (bus_we && bus_addr == A_DIR) dir_q <= wdat;
      if (bus_re) bus_rdata <= lanes(rd_mux);
    end
  end

  assign gpio_out = latch_q;
  assign gpio_oe  = (READ_ONLY != 0) ? '0 : ((DIR_IN_POL != 0) ? ~dir_q : dir_q);

  // R2: data reads return the second synchronizer stage one cycle later
  a_r2_read_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_DAT) |=> bus_rdata == lanes($past(sync2_q)));

  a_r2_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sync2_q == $past(sync1_q));

  // R12: latch moves only on a write strobe
  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(gpio_out));

  generate
    if (SET_ON && HAS_CLR != 0) begin : g_set_chk
      // R3: written ones end up high, other bits untouched
      a_r3_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET) |=>
          ((gpio_out & lanes($past(bus_wdata))) == lanes($past(bus_wdata))) &&
          ((gpio_out & ~lanes($past(bus_wdata))) == ($past(gpio_out) & ~lanes($past(bus_wdata)))));
    end
    if (CLR_ON) begin : g_clr_chk
      // R4: written ones end up low, other bits untouched
      a_r4_clr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLR) |=>
          ((gpio_out & lanes($past(bus_wdata))) == '0) &&
          ((gpio_out & ~lanes($past(bus_wdata))) == ($past(gpio_out) & ~lanes($past(bus_wdata)))));
    end
    if (SET_ON && HAS_CLR == 0) begin : g_load_chk
      // R5: set register loads directly when no clear register exists
      a_r5_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET) |=> gpio_out == lanes($past(bus_wdata)));
    end
    if (READ_ONLY != 0) begin : g_ro_chk
      // R9: no write moves the pins and no driver is enabled
      a_r9_ro_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> $stable(gpio_out) && gpio_oe == '0);
    end
  endgenerate
endmodule

// File: tb/gpio_setclr_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_setclr_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [1:0]  addr_s [4];
  logic        we_s   [4];
  logic        re_s   [4];
  logic [15:0] wd_s   [4];
  logic [15:0] pin_s  [4];

  logic [7:0]  rd_i, out_i, oe_i, rd_d, out_d, oe_d, rd_r, out_r, oe_r;
  logic [15:0] rd_b, out_b, oe_b;

  int checks = 0, fails = 0;

  // dut_i: 8 lines, set+clear, output polarity, little-endian
  gpio_setclr_ctrl #(.WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_s[0]), .bus_we(we_s[0]),
    .bus_wdata(wd_s[0][7:0]), .bus_re(re_s[0]), .bus_rdata(rd_i),
    .gpio_out(out_i), .gpio_oe(oe_i), .gpio_in(pin_s[0][7:0]));

  // dut_b: 16 lines, set only, input polarity, big-endian
  gpio_setclr_ctrl #(.WIDTH(16), .HAS_CLR(0), .DIR_IN_POL(1), .BIG_ENDIAN(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_s[1]), .bus_we(we_s[1]),
    .bus_wdata(wd_s[1]), .bus_re(re_s[1]), .bus_rdata(rd_b),
    .gpio_out(out_b), .gpio_oe(oe_b), .gpio_in(pin_s[1]));

  // dut_d: 8 lines, data register only
  gpio_setclr_ctrl #(.WIDTH(8), .HAS_SET(0), .HAS_CLR(0)) dut_d (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_s[2]), .bus_we(we_s[2]),
    .bus_wdata(wd_s[2][7:0]), .bus_re(re_s[2]), .bus_rdata(rd_d),
    .gpio_out(out_d), .gpio_oe(oe_d), .gpio_in(pin_s[2][7:0]));

  // dut_r: 8 lines, read-only
  gpio_setclr_ctrl #(.WIDTH(8), .HAS_SET(0), .HAS_CLR(0), .READ_ONLY(1)) dut_r (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_s[3]), .bus_we(we_s[3]),
    .bus_wdata(wd_s[3][7:0]), .bus_re(re_s[3]), .bus_rdata(rd_r),
    .gpio_out(out_r), .gpio_oe(oe_r), .gpio_in(pin_s[3][7:0]));

  function automatic logic [15:0] rdv(int d);
    case (d)
      0: return {8'h00, rd_i};
      1: return rd_b;
      2: return {8'h00, rd_d};
      default: return {8'h00, rd_r};
    endcase
  endfunction

  function automatic logic [15:0] outv(int d);
    case (d)
      0: return {8'h00, out_i};
      1: return out_b;
      2: return {8'h00, out_d};
      default: return {8'h00, out_r};
    endcase
  endfunction

  function automatic logic [15:0] oev(int d);
    case (d)
      0: return {8'h00, oe_i};
      1: return oe_b;
      2: return {8'h00, oe_d};
      default: return {8'h00, oe_r};
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int d, logic [1:0] a, logic [15:0] v);
    @(negedge clk);
    addr_s[d] = a; wd_s[d] = v; we_s[d] = 1'b1;
    @(negedge clk);
    we_s[d] = 1'b0;
  endtask

  task automatic rdreg(int d, logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr_s[d] = a; re_s[d] = 1'b1;
    @(negedge clk);
    re_s[d] = 1'b0;
    v = rdv(d);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [7:0] m, s, c;
    for (int d = 0; d < 4; d++) begin
      addr_s[d] = 0; we_s[d] = 0; re_s[d] = 0; wd_s[d] = 0; pin_s[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state
    chk("R11 out_i reset", outv(0), 16'h0);
    chk("R11 oe_i reset", oev(0), 16'h0);
    chk("R11 oe_b reset", oev(1), 16'h0);
    rdreg(0, 2'd3, v); chk("R11 dir_i reset", v, 16'h0000);
    rdreg(1, 2'd3, v); chk("R11 dir_b reset (input polarity)", v, 16'hFFFF);

    // R2: exhaustive pin sweep through synchronizer
    for (int p = 0; p < 256; p++) begin
      pin_s[0] = 16'(p);
      @(negedge clk);
      rdreg(0, 2'd0, v);
      chk("R1 R2 data read sweep", v, 16'(p));
    end
    // R2: a read one cycle too early still sees the old level
    pin_s[0] = 16'h00;
    @(negedge clk); @(negedge clk);
    pin_s[0] = 16'h81;
    rdreg(0, 2'd0, v); chk("R2 synchronizer depth", v, 16'h00);
    rdreg(0, 2'd0, v); chk("R2 synchronizer settled", v, 16'h81);

    // R3/R4: set/clear sweep against arithmetic model
    m = 0;
    for (int i = 0; i < 256; i++) begin
      s = 8'((i * 37) & 8'hFF);
      c = 8'((i * 91 + 5) & 8'hFF);
      wr(0, 2'd1, {8'h00, s}); m = m | s;
      chk("R3 set sweep", outv(0), {8'h00, m});
      wr(0, 2'd2, {8'h00, c}); m = m & ~c;
      chk("R4 clear sweep", outv(0), {8'h00, m});
    end
    wr(0, 2'd2, 16'hFF); wr(0, 2'd1, 16'h3C);
    rdreg(0, 2'd1, v); chk("R12 set address reads latch", v, 16'h3C);
    pin_s[0] = 16'h00;
    @(negedge clk);
    rdreg(0, 2'd0, v); chk("R2 data read is pins not latch", v, 16'h00);
    wr(0, 2'd0, 16'hFF); chk("R6 data write ignored when set exists", outv(0), 16'h3C);

    // R7: output polarity
    wr(0, 2'd3, 16'hA5); chk("R7 direction output polarity", oev(0), 16'hA5);
    rdreg(0, 2'd3, v); chk("R12 dir readback", v, 16'hA5);

    // R8/R10/R5 on big-endian input-polarity build
    wr(1, 2'd3, 16'h00FF); chk("R8 R10 direction input polarity", oev(1), 16'h00FF);
    rdreg(1, 2'd3, v); chk("R10 dir readback swapped", v, 16'h00FF);
    wr(1, 2'd1, 16'h1234); chk("R10 R5 set load swapped", outv(1), 16'h3412);
    wr(1, 2'd1, 16'h0001); chk("R5 set load drives zeros low", outv(1), 16'h0100);
    pin_s[1] = 16'hABCD;
    @(negedge clk);
    rdreg(1, 2'd0, v); chk("R10 data read swapped", v, 16'hCDAB);
    rdreg(1, 2'd2, v); chk("R12 absent clear reads zero", v, 16'h0);
    wr(1, 2'd2, 16'hFFFF); chk("R12 absent clear write ignored", outv(1), 16'h0100);

    // R6/R12: data-only build
    wr(2, 2'd0, 16'h5A); chk("R6 data write loads latch", outv(2), 16'h5A);
    wr(2, 2'd1, 16'hFF); chk("R12 absent set write ignored", outv(2), 16'h5A);
    wr(2, 2'd2, 16'hFF); chk("R12 absent clear write ignored d", outv(2), 16'h5A);
    rdreg(2, 2'd1, v); chk("R12 absent set reads zero", v, 16'h0);
    pin_s[2] = 16'h3C;
    @(negedge clk);
    rdreg(2, 2'd0, v); chk("R2 data-only reads pins", v, 16'h3C);

    // R9: read-only build
    wr(3, 2'd0, 16'hFF); chk("R9 read-only data write", outv(3), 16'h00);
    wr(3, 2'd3, 16'hFF); chk("R9 read-only no output enable", oev(3), 16'h00);
    pin_s[3] = 16'h77;
    @(negedge clk);
    rdreg(3, 2'd0, v); chk("R9 read-only pins readable", v, 16'h77);

    finish_run();
  end
endmodule